// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block lets a host with a 32-bit memory-mapped interface reach the byte-wide register file of a protocol core through a single window word. The host writes one word that holds an internal address, a write byte and a direction flag. The bridge runs the internal access over a fixed number of cycles and reports a busy flag in the same word while the access is in flight. For a read, it then places the fetched byte in the top byte of that word.

The bridge also carries a model of the core's register file. This model holds a control register, a second control register, an interrupt mask, two logical-address bytes, transmit and receive counts, a status byte, a lock-buffer byte, a wake-up control byte, and transmit and receive byte buffers. The send bit and the transfer type held in the control register are driven out to the protocol engine, which sits outside this block.

A host issues an access by writing the window. It then polls until busy reads back 0, and for a read it takes the byte from bits 31:24.

Top module: `bwin_bridge`

## Requirements
- R1: After reset, the window reads 0x00000000, `tx_send` is 0, `tx_kind` is 0, and every mapped internal register reads 0x00.
- R2: The window read word has the following layout. Bits 7:0 hold the address of the last accepted access, bits 15:8 hold its write byte, and bit 16 holds its direction (1 = write, 0 = read). Bit 23 is busy and bits 31:24 hold the read byte. Bits 22:17 always read 0.
- R3: When `win_wr` is sampled with busy clear, busy reads 1 from the next cycle. It stays at 1 for exactly ACC_LAT cycles and then returns to 0.
- R4: An accepted access with bit 16 clear reads the addressed register. The register's value appears in bits 31:24 in the same cycle that busy clears, and bits 31:24 do not change at any other time.
- R5: An accepted access with bit 16 set stores bits 15:8 into the addressed register when busy clears. A write access leaves bits 31:24 unchanged.
- R6: A `win_wr` sampled while busy is 1 is ignored. Bits 16:0 of the window keep their values, the access in flight completes with its own result, and no register is changed by the ignored request.
- R7: Internal addresses that are not mapped read as 0x00, and writes to them are discarded.
- R8: The following internal addresses are mapped, and each holds 8 bits that can be read and written:
  - 0x01: second control register
  - 0x02: interrupt mask
  - 0x05 and 0x06: logical address, low and high bytes
  - 0x07: transmit count
  - 0x08: receive count
  - 0x09: status
  - 0x10 to 0x1F: transmit buffer, 16 bytes
  - 0x20 to 0x2F: receive buffer, 16 bytes
  - 0x30: lock-buffer
  - 0x31: wake-up control
- R9: The control register at 0x00 stores only bits 2:0, and bits 7:3 read 0. Bit 0 is the send bit and drives `tx_send`. Bits 2:1 hold the transfer type and drive `tx_kind`, coded as 0 = retry, 1 = new initiator and 2 = next transfer, with 3 reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_wr | input | 1 | Host write strobe for the window word |
| win_wdata | input | 17 | Writable window fields: address 7:0, write byte 15:8, direction 16 |
| win_rdata | output | 32 | Window read word |
| tx_send | output | 1 | Send bit from the control register |
| tx_kind | output | 2 | Transfer type from the control register |

## Verification
The assertions assume that the host follows the polling rule. Under that rule, a strobe raised while busy is the only kind of overlap, and the window fields are expected to hold across it. The assertions also assume that ACC_LAT is at least 1, so that every accepted access has a busy phase they can time. The stimulus keeps to these assumptions. It waits out each access cycle by cycle before it issues the next one, except in one directed case that deliberately strobes during busy to exercise the ignore rule. The random addresses are weighted toward the mapped range, with some drawn from the full byte range so that unmapped locations are also covered.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

    localparam int WR_W  = 17;
    localparam int WIN_W = 32;

    localparam logic [7:0] TX_BASE   = 8'h10;
    localparam logic [7:0] RX_BASE   = 8'h20;
    localparam logic [7:0] CTRL_MASK = 8'h07;
    localparam int         NUM_SLOT  = 10;

    typedef enum logic [1:0] {
        KIND_RETRY = 2'd0,
        KIND_NEW   = 2'd1,
        KIND_NEXT  = 2'd2,
        KIND_RSVD  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [7:0] rdata;
        logic       busy;
        logic [5:0] rsvd;
        logic       wr;
        logic [7:0] wdata;
        logic [7:0] addr;
    } win_word_t;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic [7:0] addr;
    } acc_req_t;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } slot_t;

    function automatic slot_t slot_lookup(input logic [7:0] a);
        slot_t s;
        s.hit = 1'b1;
        case (a)
            8'h00:   s.idx = 4'd0;
            8'h01:   s.idx = 4'd1;
            8'h02:   s.idx = 4'd2;
            8'h05:   s.idx = 4'd3;
            8'h06:   s.idx = 4'd4;
            8'h07:   s.idx = 4'd5;
            8'h08:   s.idx = 4'd6;
            8'h09:   s.idx = 4'd7;
            8'h30:   s.idx = 4'd8;
            8'h31:   s.idx = 4'd9;
            default: begin s.hit = 1'b0; s.idx = 4'd0; end
        endcase
        return s;
    endfunction

    function automatic logic in_buf(input logic [7:0] a, input logic [7:0] base,
                                    input int len);
        return (a >= base) && ({24'd0, a} < ({24'd0, base} + len));
    endfunction

endpackage

// File: rtl/bwin_window.sv
module bwin_window
    import bwin_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_wr,
    input  logic [WR_W-1:0]  win_wdata,
    input  logic [7:0]       rd_byte,
    output logic [WIN_W-1:0] win_rdata,
    output acc_req_t         req,
    output logic             done
);
    localparam int CNT_W = $clog2(ACC_LAT + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       rd_q;
    acc_req_t         req_q;
    win_word_t        w;

    assign done = busy && (cnt == CNT_W'(1));
    assign req  = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            rd_q  <= '0;
            req_q <= '0;
        end else if (win_wr && !busy) begin
            req_q.wr   <= win_wdata[16];
            req_q.data <= win_wdata[15:8];
            req_q.addr <= win_wdata[7:0];
            busy       <= 1'b1;
            cnt        <= CNT_W'(ACC_LAT);
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (done) begin
                busy <= 1'b0;
                if (!req_q.wr) rd_q <= rd_byte;
            end
        end
    end

    always_comb begin
        w       = '0;
        w.addr  = req_q.addr;
        w.wdata = req_q.data;
        w.wr    = req_q.wr;
        w.busy  = busy;
        w.rdata = rd_q;
    end

    assign win_rdata = w;

endmodule

// File: rtl/bwin_regfile.sv
module bwin_regfile
    import bwin_pkg::*;
#(
    parameter int BUF_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       send,
    output logic [1:0] kind
);
    localparam int IDX_W = (BUF_LEN > 1) ? $clog2(BUF_LEN) : 1;

    logic [7:0] slot_q [NUM_SLOT];
    logic [7:0] tx_q   [BUF_LEN];
    logic [7:0] rx_q   [BUF_LEN];

    slot_t      sl;
    logic       tx_hit, rx_hit;
    logic [IDX_W-1:0] bidx;

    assign sl     = slot_lookup(addr);
    assign tx_hit = in_buf(addr, TX_BASE, BUF_LEN);
    assign rx_hit = in_buf(addr, RX_BASE, BUF_LEN);
    assign bidx   = addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        localparam logic [7:0] MASK = (i == 0) ? CTRL_MASK : 8'hFF;
        always_ff @(posedge clk) begin
            if (rst) slot_q[i] <= '0;
            else if (wr_en && sl.hit && (sl.idx == 4'(i))) slot_q[i] <= wdata & MASK;
        end
    end

    for (genvar i = 0; i < BUF_LEN; i++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_q[i] <= '0;
                rx_q[i] <= '0;
            end else if (wr_en && (bidx == IDX_W'(i))) begin
                if (tx_hit) tx_q[i] <= wdata;
                if (rx_hit) rx_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (sl.hit)      rdata = slot_q[sl.idx];
        else if (tx_hit) rdata = tx_q[bidx];
        else if (rx_hit) rdata = rx_q[bidx];
    end

    assign send = slot_q[0][0];
    assign kind = slot_q[0][2:1];

endmodule

// File: rtl/bwin_bridge.sv
module bwin_bridge
    import bwin_pkg::*;
#(
    parameter int ACC_LAT = 4,
    parameter int BUF_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_wr,
    input  logic [WR_W-1:0]  win_wdata,
    output logic [WIN_W-1:0] win_rdata,
    output logic             tx_send,
    output logic [1:0]       tx_kind
);
    acc_req_t   req;
    logic       done;
    logic [7:0] rd_byte;

    bwin_window #(.ACC_LAT(ACC_LAT)) u_window (
        .clk       (clk),
        .rst       (rst),
        .win_wr    (win_wr),
        .win_wdata (win_wdata),
        .rd_byte   (rd_byte),
        .win_rdata (win_rdata),
        .req       (req),
        .done      (done)
    );

    bwin_regfile #(.BUF_LEN(BUF_LEN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (done && req.wr),
        .addr  (req.addr),
        .wdata (req.data),
        .rdata (rd_byte),
        .send  (tx_send),
        .kind  (tx_kind)
    );

endmodule

// File: rtl/bwin_chk.sv
module bwin_chk #(
    parameter int ACC_LAT = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        win_wr,
    input logic [31:0] win_rdata
);
    logic busy;
    int unsigned run;

    assign busy = win_rdata[23];

    always_ff @(posedge clk) begin
        if (rst || !busy) run <= 0;
        else              run <= run + 1;
    end

    a_r3_busy_rises: assert property (@(posedge clk) disable iff (rst)
        (win_wr && !busy) |=> busy);

    a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == ACC_LAT));

    a_r3_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < ACC_LAT));

    a_r4_rdata_only_at_end: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(win_rdata[31:24]));

    a_r6_ignore_while_busy: assert property (@(posedge clk) disable iff (rst)
        (win_wr && busy) |=> $stable(win_rdata[16:0]));

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        win_rdata[22:17] == 6'd0);

endmodule

bind bwin_bridge bwin_chk #(.ACC_LAT(ACC_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_wr    (win_wr),
    .win_rdata (win_rdata)
);

// File: tb/bwin_bridge_bench.sv
module bwin_bridge_bench;
    localparam int LAT = 4;
    localparam int BUF = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_wr = 1'b0;
    logic [16:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic        tx_send;
    logic [1:0]  tx_kind;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [256];
    logic [7:0] last_rd = 8'h00;

    bwin_bridge #(.ACC_LAT(LAT), .BUF_LEN(BUF)) u_bwin_bridge (
        .clk(clk), .rst(rst), .win_wr(win_wr), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .tx_send(tx_send), .tx_kind(tx_kind)
    );

    always #5 clk = ~clk;

    function automatic bit mapped(input logic [7:0] a);
        return (a inside {8'h00, 8'h01, 8'h02, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09})
            || (a >= 8'h10 && a <= 8'h31);
    endfunction

    function automatic logic [7:0] kept(input logic [7:0] a, input logic [7:0] d);
        if (!mapped(a)) return 8'h00;
        if (a == 8'h00) return d & 8'h07;
        return d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                          input string tag);
        @(negedge clk);
        win_wr    = 1'b1;
        win_wdata = {wr, d, a};
        @(negedge clk);
        win_wr = 1'b0;
        check({tag, " R3 busy set"}, {31'd0, win_rdata[23]}, 32'd1);
        repeat (LAT - 1) @(negedge clk);
        check({tag, " R3 busy held"}, {31'd0, win_rdata[23]}, 32'd1);
        @(negedge clk);
        if (wr) model[a] = kept(a, d);
        else    last_rd  = model[a];
        check({tag, " R2 R4 R5 window"}, win_rdata, {last_rd, 1'b0, 6'd0, wr, d, a});
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 window after reset", win_rdata, 32'd0);
        check("R1 outputs after reset", {29'd0, tx_send, tx_kind}, 32'd0);
        access(1'b0, 8'h31, 8'h00, "R1 read wake");
        access(1'b0, 8'h2F, 8'h00, "R1 read rx end");

        // R8: every mapped scalar and both buffers
        foreach (model[a]) begin
            if (mapped(8'(a)) && a != 0) access(1'b1, 8'(a), 8'(a) ^ 8'hA5, "R8 fill");
        end
        foreach (model[a]) begin
            if (mapped(8'(a)) && a != 0) access(1'b0, 8'(a), 8'h00, "R8 readback");
        end

        // R9: control register masking and outputs
        access(1'b1, 8'h00, 8'hFF, "R9 ctrl all");
        check("R9 send/kind all", {29'd0, tx_send, tx_kind}, {29'd0, 1'b1, 2'd3});
        access(1'b0, 8'h00, 8'h00, "R9 ctrl read");
        access(1'b1, 8'h00, 8'h04, "R9 ctrl next");
        check("R9 send/kind next", {29'd0, tx_send, tx_kind}, {29'd0, 1'b0, 2'd2});
        access(1'b1, 8'h00, 8'h03, "R9 ctrl new send");
        check("R9 send/kind new", {29'd0, tx_send, tx_kind}, {29'd0, 1'b1, 2'd1});

        // R7: unmapped addresses
        access(1'b1, 8'h03, 8'hAA, "R7 write hole");
        access(1'b0, 8'h03, 8'h00, "R7 read hole");
        access(1'b1, 8'hFF, 8'h55, "R7 write top");
        access(1'b0, 8'hFF, 8'h00, "R7 read top");
        access(1'b0, 8'h32, 8'h00, "R7 read past map");

        // R6: strobe during busy is ignored
        access(1'b1, 8'h11, 8'h5A, "R6 setup");
        access(1'b1, 8'h12, 8'h3C, "R6 setup2");
        @(negedge clk);
        win_wr    = 1'b1;
        win_wdata = {1'b0, 8'h00, 8'h11};
        @(negedge clk);
        win_wdata = {1'b1, 8'hEE, 8'h12};
        @(negedge clk);
        win_wr = 1'b0;
        check("R6 fields held", {15'd0, win_rdata[16:0]}, {15'd0, 1'b0, 8'h00, 8'h11});
        repeat (LAT - 1) @(negedge clk);
        last_rd = 8'h5A;
        check("R6 first access result", win_rdata, {8'h5A, 1'b0, 6'd0, 1'b0, 8'h00, 8'h11});
        access(1'b0, 8'h12, 8'h00, "R6 target untouched");

        // random mix, checked against the model
        for (int n = 0; n < 300; n++) begin
            logic [7:0] a;
            bit wr;
            a  = ($urandom % 4 != 0) ? 8'($urandom % 52) : 8'($urandom);
            wr = $urandom % 2;
            access(wr, a, 8'($urandom), "R4 R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule